// File: doc/BRIEF.md
# Thread Block Dispatcher with Warp Partitioning

This block takes one kernel launch, given as a number of thread blocks and a thread count per block. It assigns the blocks, lowest index first, to a small pool of compute units. Each unit can hold a bounded number of blocks at the same time. After a block is placed on a unit, the dispatcher cuts it into warps of 32 consecutive threads. It emits one warp per handshake on a valid/ready stream. Each warp carries the unit, the block index, the warp index inside the block, and a 32-bit mask of the lanes that hold real threads.

Compute units report that a block has finished by pulsing their bit of `unitDone`. That pulse frees one slot on the unit, and the next pending block can go there. A block stays on the unit that first received it. The kernel counts as finished only after every block has been handed out and every block has reported completion. The `kernelDone` flag then stays high until the next launch is accepted.

Top module: `block_dispatcher`

## Requirements
- R1: While no kernel is running, a request with a block count of at least 1 and a thread count from 1 to 1024 raises `launchAck` in the same cycle. A request with a zero block count, a zero thread count or more than 1024 threads raises `launchReject` instead. While a kernel is running, a request raises neither signal.
- R2: Blocks are issued in order 0, 1, ... up to the block count minus 1. Each block is issued as warps 0 up to ceil(threads/32)-1, all of them before any warp of the next block.
- R3: In `warpMask`, bit i covers thread warpIdx*32+i of the block. The bit is 1 exactly when that thread number is below the per-block thread count. Every warp is therefore all ones except the last warp of a block whose size is not a multiple of 32.
- R4: A unit receives a new block only while the number of blocks it holds (assigned minus completed) is below MAX_RES. When no unit is below that limit, no warp is offered.
- R5: When several units can take a block, the choice is the first eligible unit at or after the one that follows the last assigned unit, wrapping around. The search starts at unit 0 after reset.
- R6: Every warp of a block carries the same unit number.
- R7: While `warpValid` is high and `warpReady` is low, `warpValid` stays high and the unit, block, warp index and mask stay unchanged.
- R8: A `unitDone` pulse on a unit that holds no block is ignored. It frees no capacity and counts as no completion.
- R9: A completion pulse frees one slot on that unit, and a dispatch that was stalled for lack of capacity resumes on the freed unit.
- R10: `kernelDone` rises only after all blocks have been issued and the same number of completions has been counted. It stays high until the next accepted launch.
- R11: After reset, `warpValid`, `launchAck` and `kernelDone` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| launchReq | input | 1 | Launch request |
| launchGrid | input | BLK_W | Number of thread blocks in the launch |
| launchThreads | input | THR_W | Threads per block |
| launchAck | output | 1 | Launch accepted (same cycle as the request) |
| launchReject | output | 1 | Launch refused because of bad sizes |
| unitDone | input | UNITS | One bit per unit: a block on that unit completed |
| warpValid | output | 1 | A warp is offered |
| warpReady | input | 1 | The consumer takes the offered warp |
| warpUnit | output | UNIT_W | Unit that owns the warp's block |
| warpBlock | output | BLK_W | Block index |
| warpIdx | output | WIDX_W | Warp index within the block |
| warpMask | output | LANES | Active-lane mask |
| kernelDone | output | 1 | All blocks issued and completed |

## Verification
The hardest case to reach from the ports is a dispatch stall in which every unit is full, followed by a release that must land on one unit against the round-robin order. The directed run uses blocks small enough that the first eight blocks fill all four units with no completions. It then confirms that no warp is offered. Next it frees a slot on a unit in the middle of the rotation, and after that one on the unit the pointer has already passed. A further directed step sends completion pulses to units that hold nothing, before any kernel runs. A miscounted slot would then show up as a changed unit pattern or an early `kernelDone`. Random kernels add odd thread counts, random back-pressure and random completions.

// File: rtl/bd_pkg.sv
package bd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PICK  = 2'd1,
    PH_ISSUE = 2'd2,
    PH_DRAIN = 2'd3
  } phase_e;

  typedef struct packed {
    logic loadKernel;
    logic assignBlock;
    logic stepWarp;
    logic stepBlock;
  } strobe_t;

endpackage

// File: rtl/bd_datapath.sv
module bd_datapath
  import bd_pkg::*;
#(
  parameter int UNITS   = 4,
  parameter int MAX_RES = 2,
  parameter int BLK_W   = 16,
  parameter int THR_W   = 11,
  parameter int LANES   = 32,
  parameter int WIDX_W  = 5,
  parameter int UNIT_W  = 2,
  parameter int RES_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [BLK_W-1:0]  gridIn,
  input  logic [THR_W-1:0]  threadsIn,
  input  logic [UNITS-1:0]  unitDone,
  output logic              anyEligible,
  output logic              allIssued,
  output logic              allRetired,
  output logic              lastWarp,
  output logic [UNIT_W-1:0] curUnit,
  output logic [BLK_W-1:0]  curBlock,
  output logic [WIDX_W-1:0] warpIdx,
  output logic [LANES-1:0]  warpMask
);

  localparam int LANE_SH = $clog2(LANES);

  logic [BLK_W-1:0]  gridReg;
  logic [THR_W-1:0]  threadsReg;
  logic [BLK_W-1:0]  retired;
  logic [UNIT_W-1:0] rrPtr;
  logic [RES_W-1:0]  resident [UNITS];
  logic [UNITS-1:0]  eligible;
  logic [UNITS-1:0]  doneTaken;
  logic [UNIT_W-1:0] pickUnit;
  logic              pickFound;
  logic [THR_W-1:0]  tMinus;
  logic [THR_W-1:0]  laneBase;
  logic [THR_W-1:0]  remaining;

  // round-robin search starting at the pointer
  always_comb begin
    pickFound = 1'b0;
    pickUnit  = '0;
    for (int off = 0; off < UNITS; off++) begin
      if (!pickFound && eligible[(int'(rrPtr) + off) % UNITS]) begin
        pickFound = 1'b1;
        pickUnit  = UNIT_W'((int'(rrPtr) + off) % UNITS);
      end
    end
  end

  assign anyEligible = pickFound;
  assign allIssued   = (curBlock == gridReg);
  assign allRetired  = (retired == gridReg);

  // warp geometry
  assign tMinus    = threadsReg - THR_W'(1);
  assign lastWarp  = (warpIdx == WIDX_W'(tMinus >> LANE_SH));
  assign laneBase  = THR_W'(warpIdx) << LANE_SH;
  assign remaining = threadsReg - laneBase;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign warpMask[l] = (THR_W'(l) < remaining);
  end

  // per-unit occupancy
  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    logic takeHere;
    assign eligible[u]  = (resident[u] < RES_W'(MAX_RES));
    assign doneTaken[u] = unitDone[u] && (resident[u] != '0);
    assign takeHere     = strobe.assignBlock && (pickUnit == UNIT_W'(u));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        resident[u] <= '0;
      end else if (takeHere && !doneTaken[u]) begin
        resident[u] <= resident[u] + RES_W'(1);
      end else if (!takeHere && doneTaken[u]) begin
        resident[u] <= resident[u] - RES_W'(1);
      end
    end

    p_res_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
      takeHere |=> (resident[u] <= RES_W'(MAX_RES)));
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rstN)
      (resident[u] == '0 && !takeHere) |=> (resident[u] == '0));
  end

  // kernel registers and counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gridReg    <= '0;
      threadsReg <= '0;
      retired    <= '0;
      rrPtr      <= '0;
      curUnit    <= '0;
      curBlock   <= '0;
      warpIdx    <= '0;
    end else begin
      if (strobe.loadKernel) begin
        gridReg    <= gridIn;
        threadsReg <= threadsIn;
        curBlock   <= '0;
        warpIdx    <= '0;
        retired    <= '0;
      end else begin
        retired <= retired + BLK_W'($countones(doneTaken));
      end
      if (strobe.assignBlock) begin
        curUnit <= pickUnit;
        rrPtr   <= (pickUnit == UNIT_W'(UNITS - 1)) ? '0 : pickUnit + UNIT_W'(1);
        warpIdx <= '0;
      end
      if (strobe.stepWarp)  warpIdx  <= warpIdx + WIDX_W'(1);
      if (strobe.stepBlock) curBlock <= curBlock + BLK_W'(1);
    end
  end

  p_block_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepBlock |=> (curBlock == BLK_W'($past(curBlock) + 1'b1)));
  p_unit_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepWarp |=> (curUnit == $past(curUnit)));

endmodule

// File: rtl/bd_ctrl.sv
module bd_ctrl
  import bd_pkg::*;
#(
  parameter int BLK_W       = 16,
  parameter int THR_W       = 11,
  parameter int MAX_THREADS = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             launchReq,
  input  logic [BLK_W-1:0] gridIn,
  input  logic [THR_W-1:0] threadsIn,
  input  logic             warpReady,
  input  logic             anyEligible,
  input  logic             allIssued,
  input  logic             allRetired,
  input  logic             lastWarp,
  output strobe_t          strobe,
  output logic             launchAck,
  output logic             launchReject,
  output logic             warpValid,
  output logic             kernelDone
);

  phase_e phase, phaseNext;
  logic   launchOk;

  assign launchOk = (gridIn != '0) && (threadsIn != '0) &&
                    (threadsIn <= THR_W'(MAX_THREADS));

  always_comb begin
    phaseNext    = phase;
    strobe       = '0;
    launchAck    = 1'b0;
    launchReject = 1'b0;
    warpValid    = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        launchAck    = launchReq && launchOk;
        launchReject = launchReq && !launchOk;
        if (launchAck) begin
          strobe.loadKernel = 1'b1;
          phaseNext         = PH_PICK;
        end
      end
      PH_PICK: begin
        if (allIssued) begin
          phaseNext = PH_DRAIN;
        end else if (anyEligible) begin
          strobe.assignBlock = 1'b1;
          phaseNext          = PH_ISSUE;
        end
      end
      PH_ISSUE: begin
        warpValid = 1'b1;
        if (warpReady) begin
          if (lastWarp) begin
            strobe.stepBlock = 1'b1;
            phaseNext        = PH_PICK;
          end else begin
            strobe.stepWarp = 1'b1;
          end
        end
      end
      PH_DRAIN: begin
        if (allRetired) phaseNext = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      kernelDone <= 1'b0;
    end else begin
      phase <= phaseNext;
      if (strobe.loadKernel) begin
        kernelDone <= 1'b0;
      end else if (phase == PH_DRAIN && allRetired) begin
        kernelDone <= 1'b1;
      end
    end
  end

  p_ack_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    launchAck |-> (!warpValid && !kernelDone == !kernelDone && threadsIn <= THR_W'(MAX_THREADS)));
  p_done_rise_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(kernelDone) |-> (allIssued && allRetired));
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    kernelDone |-> !warpValid);

endmodule

// File: rtl/block_dispatcher.sv
module block_dispatcher
  import bd_pkg::*;
#(
  parameter int UNITS       = 4,
  parameter int MAX_RES     = 2,
  parameter int BLK_W       = 16,
  parameter int LANES       = 32,
  parameter int MAX_THREADS = 1024,
  parameter int THR_W       = $clog2(MAX_THREADS + 1),
  parameter int WIDX_W      = (MAX_THREADS / LANES > 1) ? $clog2(MAX_THREADS / LANES) : 1,
  parameter int UNIT_W      = (UNITS > 1) ? $clog2(UNITS) : 1,
  parameter int RES_W       = $clog2(MAX_RES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              launchReq,
  input  logic [BLK_W-1:0]  launchGrid,
  input  logic [THR_W-1:0]  launchThreads,
  output logic              launchAck,
  output logic              launchReject,
  input  logic [UNITS-1:0]  unitDone,
  output logic              warpValid,
  input  logic              warpReady,
  output logic [UNIT_W-1:0] warpUnit,
  output logic [BLK_W-1:0]  warpBlock,
  output logic [WIDX_W-1:0] warpIdx,
  output logic [LANES-1:0]  warpMask,
  output logic              kernelDone
);

  strobe_t strobe;
  logic    anyEligible, allIssued, allRetired, lastWarp;

  bd_ctrl #(
    .BLK_W(BLK_W), .THR_W(THR_W), .MAX_THREADS(MAX_THREADS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .launchReq(launchReq), .gridIn(launchGrid),
    .threadsIn(launchThreads), .warpReady(warpReady), .anyEligible(anyEligible),
    .allIssued(allIssued), .allRetired(allRetired), .lastWarp(lastWarp),
    .strobe(strobe), .launchAck(launchAck), .launchReject(launchReject),
    .warpValid(warpValid), .kernelDone(kernelDone)
  );

  bd_datapath #(
    .UNITS(UNITS), .MAX_RES(MAX_RES), .BLK_W(BLK_W), .THR_W(THR_W),
    .LANES(LANES), .WIDX_W(WIDX_W), .UNIT_W(UNIT_W), .RES_W(RES_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .gridIn(launchGrid),
    .threadsIn(launchThreads), .unitDone(unitDone), .anyEligible(anyEligible),
    .allIssued(allIssued), .allRetired(allRetired), .lastWarp(lastWarp),
    .curUnit(warpUnit), .curBlock(warpBlock), .warpIdx(warpIdx), .warpMask(warpMask)
  );

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (warpValid && !warpReady) |=> (warpValid && $stable(warpUnit) && $stable(warpBlock)
                                   && $stable(warpIdx) && $stable(warpMask)));
  p_full_mask_r3: assert property (@(posedge clk) disable iff (!rstN)
    (warpValid && !lastWarp) |-> (&warpMask));
  p_mask_lane0_r3: assert property (@(posedge clk) disable iff (!rstN)
    warpValid |-> warpMask[0]);

endmodule

// File: tb/sim_block_dispatcher.sv
`timescale 1ns/1ps
module sim_block_dispatcher;
  localparam int UNITS = 4;
  localparam int MAX_RES = 2;
  localparam int BLK_W = 16;
  localparam int LANES = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        launchReq = 1'b0;
  logic [15:0] launchGrid = '0;
  logic [10:0] launchThreads = '0;
  logic        launchAck, launchReject;
  logic [3:0]  unitDone = '0;
  logic        warpValid;
  logic        warpReady = 1'b0;
  logic [1:0]  warpUnit;
  logic [15:0] warpBlock;
  logic [4:0]  warpIdx;
  logic [31:0] warpMask;
  logic        kernelDone;

  block_dispatcher #(.UNITS(UNITS), .MAX_RES(MAX_RES), .BLK_W(BLK_W), .LANES(LANES)) u0 (
    .clk(clk), .rstN(rstN), .launchReq(launchReq), .launchGrid(launchGrid),
    .launchThreads(launchThreads), .launchAck(launchAck), .launchReject(launchReject),
    .unitDone(unitDone), .warpValid(warpValid), .warpReady(warpReady), .warpUnit(warpUnit),
    .warpBlock(warpBlock), .warpIdx(warpIdx), .warpMask(warpMask), .kernelDone(kernelDone)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int expBlk, expW, curThr, blkUnit;
  int benchRes [UNITS];
  int firstUnit [64];
  bit inKernel, earlyDone, prevStall;
  logic [1:0]  pUnit;
  logic [15:0] pBlock;
  logic [4:0]  pIdx;
  logic [31:0] pMask;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expMask(input int thr, input int w);
    logic [31:0] m;
    for (int l = 0; l < 32; l++) m[l] = ((w * 32 + l) < thr);
    return m;
  endfunction

  function automatic bit allZero();
    for (int u = 0; u < UNITS; u++) if (benchRes[u] != 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic cycle(input logic rdy, input logic [3:0] dn);
    @(negedge clk);
    warpReady = rdy;
    unitDone  = dn;
    #1;
    if (inKernel && kernelDone) earlyDone = 1'b1;
    if (prevStall)
      check(warpValid && warpUnit == pUnit && warpBlock == pBlock && warpIdx == pIdx
            && warpMask == pMask, "R7 hold under back-pressure", {warpBlock, warpIdx}, {pBlock, pIdx});
    prevStall = warpValid && !rdy;
    pUnit = warpUnit; pBlock = warpBlock; pIdx = warpIdx; pMask = warpMask;
    if (warpValid && rdy) begin
      check(int'(warpBlock) == expBlk, "R2 block order", warpBlock, expBlk);
      check(int'(warpIdx) == expW, "R2 warp index", warpIdx, expW);
      check(warpMask == expMask(curThr, expW), "R3 lane mask", warpMask, expMask(curThr, expW));
      if (expW == 0) begin
        check(benchRes[warpUnit] < MAX_RES, "R4 capacity", benchRes[warpUnit], MAX_RES - 1);
        blkUnit = int'(warpUnit);
        firstUnit[expBlk % 64] = int'(warpUnit);
        benchRes[warpUnit]++;
      end else begin
        check(int'(warpUnit) == blkUnit, "R6 unit fixed", warpUnit, blkUnit);
      end
      if ((expW + 1) * 32 >= curThr) begin
        expBlk++;
        expW = 0;
      end else begin
        expW++;
      end
    end
    for (int u = 0; u < UNITS; u++) if (dn[u] && benchRes[u] > 0) benchRes[u]--;
  endtask

  task automatic launch(input int grid, input int thr, input bit expOk);
    @(negedge clk);
    warpReady = 1'b0;
    unitDone = '0;
    launchReq = 1'b1;
    launchGrid = 16'(grid);
    launchThreads = 11'(thr);
    #1;
    check(launchAck == expOk, "R1 ack", launchAck, expOk);
    check(launchReject == !expOk, "R1 reject", launchReject, !expOk);
    @(negedge clk);
    launchReq = 1'b0;
    if (expOk) begin
      expBlk = 0; expW = 0; curThr = thr;
      inKernel = 1'b1; earlyDone = 1'b0; prevStall = 1'b0;
    end
  endtask

  task automatic finishKernel(input int grid);
    bit seen;
    seen = 1'b0;
    inKernel = 1'b0;
    check(!earlyDone, "R10 no early done", earlyDone, 0);
    check(expBlk == grid, "R2 block count", expBlk, grid);
    for (int i = 0; i < 10; i++) begin
      cycle(1'b0, 4'b0000);
      if (kernelDone) seen = 1'b1;
    end
    check(seen && kernelDone, "R10 done raised and held", kernelDone, 1);
  endtask

  task automatic runKernel(input int grid, input int thr);
    int guard;
    logic [3:0] dn;
    logic rdy;
    guard = 0;
    launch(grid, thr, 1'b1);
    while (!(expBlk == grid && allZero()) && guard < 20000) begin
      rdy = (($urandom % 10) < 7);
      for (int u = 0; u < UNITS; u++) dn[u] = (benchRes[u] > 0) && (($urandom % 4) == 0);
      cycle(rdy, dn);
      guard++;
    end
    finishKernel(grid);
  endtask

  initial begin
    #(150000 * 10);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int thr;
    void'($urandom(32'd20240611));
    for (int u = 0; u < UNITS; u++) benchRes[u] = 0;
    inKernel = 1'b0; earlyDone = 1'b0; prevStall = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R11 reset state
    check(!warpValid && !launchAck && !kernelDone, "R11 reset state",
          {warpValid, launchAck, kernelDone}, 0);

    // R1 rejects
    launch(0, 40, 1'b0);
    launch(3, 0, 1'b0);
    launch(3, 1025, 1'b0);

    // R8 stray completions on empty units
    cycle(1'b0, 4'b1111);
    cycle(1'b0, 4'b0000);
    check(!kernelDone && !warpValid, "R8 stray done ignored", kernelDone, 0);

    // directed: fill every unit, then release out of rotation order (R4 R5 R9)
    launch(10, 40, 1'b1);
    for (int i = 0; i < 40; i++) cycle(1'b1, 4'b0000);
    for (int b = 0; b < 8; b++)
      check(firstUnit[b] == (b % 4), "R5 round-robin order", firstUnit[b], b % 4);
    check(expBlk == 8, "R4 stall at full", expBlk, 8);
    @(negedge clk); #1;
    check(!warpValid, "R4 no offer when full", warpValid, 0);
    launchReq = 1'b1; launchGrid = 16'd2; launchThreads = 11'd32;
    #1;
    check(!launchAck && !launchReject, "R1 busy request ignored", {launchAck, launchReject}, 0);
    @(negedge clk);
    launchReq = 1'b0;
    cycle(1'b1, 4'b0100);
    for (int i = 0; i < 10; i++) cycle(1'b1, 4'b0000);
    check(expBlk == 9 && firstUnit[8] == 2, "R9 freed unit refilled", firstUnit[8], 2);
    cycle(1'b1, 4'b0001);
    for (int i = 0; i < 10; i++) cycle(1'b1, 4'b0000);
    check(expBlk == 10 && firstUnit[9] == 0, "R5 skip full unit", firstUnit[9], 0);
    cycle(1'b1, 4'b1111);
    cycle(1'b1, 4'b0000);
    cycle(1'b1, 4'b0000);
    check(!kernelDone, "R10 done waits for completions", kernelDone, 0);
    cycle(1'b1, 4'b1111);
    finishKernel(10);

    // R3 corner sizes and random kernels
    runKernel(3, 33);
    runKernel(2, 1024);
    runKernel(5, 1);
    for (int k = 0; k < 8; k++) begin
      case ($urandom % 6)
        0: thr = 31;
        1: thr = 32;
        2: thr = 65;
        3: thr = 1000;
        default: thr = 1 + int'($urandom % 300);
      endcase
      runKernel(1 + int'($urandom % 12), thr);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule